// File: doc/BRIEF.md
# Two-port serial ATA bridge PHY bring-up sequencer

This block runs the power-up, reset and shutdown sequences for the two ports of a parallel-to-serial ATA bridge adapter. Each port has a clock enable, a reset line, a control register write path and a PHY-ready status input. A start command turns the port clock on, waits a settle time, writes the setup word to the port control register, waits again and then samples PHY ready at a fixed poll interval. Polling stops at the first ready sample or after a bounded number of samples that spans the total timeout. On success the port is reported online. A start that times out gates the port clock off again and reports an error.

A reset command pulses the port reset for one cycle and then runs the same settle, control-write and poll steps. A stop command only removes the port clock. Every delay is a whole number of milliseconds counted in clock cycles from a cycles-per-millisecond parameter. While a sequence runs the block is busy and ignores new commands. Each sequence ends with a one-cycle done pulse and a pass/fail result.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset both port clock enables, both online flags, both port resets, busy and done are 0.
- R2: A start command (cmd_op = 1) accepted at clock edge 0 raises port_clk_en for cmd_port from edge 0 onward, and busy stays high until the done pulse.
- R3: Each setup writes the control word exactly once, with ctrl_port equal to the command port. The word has bit 0 (enable) and bit 4 (hot-plug detect) set. Bit 1 (slave) is set only for port 0 in mux mode 2 or for port 1 in mux mode 3. All other bits are 0, which gives 0x0011 or 0x0013.
- R4: With D = SETTLE_MS*CYC_PER_MS and P = POLL_MS*CYC_PER_MS, a start command writes the control word in the cycle after edge D. The k-th PHY-ready sample is taken at edge 2D+1+k(P+1). A reset command shifts every one of these points one cycle later.
- R5: If the sample finds phy_ready of the port high, done pulses with result_ok = 1 and online of that port goes high at the same edge.
- R6: After NPOLL = ceil((TIMEOUT_MS-SETTLE_MS)/POLL_MS) low samples, done pulses with result_ok = 0 and online stays 0. For a start command port_clk_en of that port also returns to 0.
- R7: A reset command (cmd_op = 2) drives port_rst of that port high for exactly one cycle, the cycle after acceptance. It then runs setup. A failed reset leaves port_clk_en unchanged.
- R8: A stop command (cmd_op = 3) clears port_clk_en and online of its port and pulses done with result_ok = 1 at the accepting edge.
- R9: A command presented while busy is ignored: it does not change the port clock enables, the sequence or its timing.
- R10: done is high for a single cycle per sequence. A sequence on one port leaves the clock enable and online flag of the other port unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 none, 1 start, 2 reset, 3 stop |
| cmd_port | input | 1 | Target port |
| mux_mode | input | 2 | Routing mode that selects the slave bit of the setup word |
| phy_ready | input | 2 | PHY ready status, one bit per port |
| port_clk_en | output | 2 | Port clock enables |
| port_rst | output | 2 | Port reset pulses |
| ctrl_we | output | 1 | Control register write strobe |
| ctrl_port | output | 1 | Port addressed by the write |
| ctrl_data | output | 16 | Control word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| result_ok | output | 1 | Result of the last sequence |
| online | output | 2 | Port online flags |

## Verification
The bench builds the block with CYC_PER_MS = 4, so a 10 ms settle is 40 cycles and a 100 ms poll is 400 cycles. A full timeout of ten samples then completes in about 4100 cycles. At this size the exact cycle of every control write and sample can be checked against the R4 formula, including the last-sample timeout case, a ready that arrives between samples and a command injected in the middle of a sequence.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

    localparam int NPORTS = 2;
    localparam int CTRL_W = 16;

    // control word bit positions (decoded by the adapter)
    localparam int CB_EN      = 0;
    localparam int CB_SLAVE   = 1;
    localparam int CB_HOTPLUG = 4;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_START = 2'd1,
        OP_RESET = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_RSTP, S_CLKSET, S_CTRL, S_PHYSET, S_PWAIT, S_SAMPLE
    } st_e;

    typedef struct packed {
        op_e        op;
        logic       port;
        logic [1:0] mux;
    } cmd_t;

    function automatic logic [CTRL_W-1:0] ctrl_word(input logic port, input logic [1:0] mux);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[CB_EN]      = 1'b1;
        w[CB_HOTPLUG] = 1'b1;
        w[CB_SLAVE]   = (!port && mux == 2'd2) || (port && mux == 2'd3);
        return w;
    endfunction

endpackage

// File: rtl/bringup_timer.sv
module bringup_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/bringup_port.sv
module bringup_port (
    input  logic clk,
    input  logic rst,
    input  logic set_clk,
    input  logic clr_clk,
    input  logic set_online,
    input  logic clr_online,
    output logic clk_en,
    output logic online
);
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en <= 1'b0;
            online <= 1'b0;
        end else begin
            if (set_clk)         clk_en <= 1'b1;
            else if (clr_clk)    clk_en <= 1'b0;
            if (set_online)      online <= 1'b1;
            else if (clr_online) online <= 1'b0;
        end
    end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import bringup_pkg::*;
#(
    parameter int CYC_PER_MS = 100000,
    parameter int SETTLE_MS  = 10,
    parameter int POLL_MS    = 100,
    parameter int TIMEOUT_MS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_port,
    input  logic [1:0]        mux_mode,
    input  logic [1:0]        phy_ready,
    output logic [1:0]        port_clk_en,
    output logic [1:0]        port_rst,
    output logic              ctrl_we,
    output logic              ctrl_port,
    output logic [CTRL_W-1:0] ctrl_data,
    output logic              busy,
    output logic              done,
    output logic              result_ok,
    output logic [1:0]        online
);
    localparam int SET_CYC  = SETTLE_MS * CYC_PER_MS;
    localparam int POLL_CYC = POLL_MS * CYC_PER_MS;
    localparam int MAX_CYC  = (SET_CYC > POLL_CYC) ? SET_CYC : POLL_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam int NPOLL_R  = (TIMEOUT_MS - SETTLE_MS + POLL_MS - 1) / POLL_MS;
    localparam int NPOLL    = (NPOLL_R < 1) ? 1 : NPOLL_R;
    localparam int PW       = $clog2(NPOLL + 1);
    localparam logic [TW-1:0] SET_LD  = TW'(SET_CYC - 1);
    localparam logic [TW-1:0] POLL_LD = TW'(POLL_CYC - 1);

    st_e           state;
    cmd_t          cur;
    cmd_t          cmd_in;
    logic [PW-1:0] poll_cnt;
    logic          done_q, ok_q;
    logic          accept, hit, last, succ, fail;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;

    assign cmd_in = '{op: op_e'(cmd_op), port: cmd_port, mux: mux_mode};
    assign accept = (state == S_IDLE) && cmd_valid && (cmd_in.op != OP_NOP);
    assign hit    = phy_ready[cur.port];
    assign last   = (poll_cnt == PW'(NPOLL - 1));
    assign succ   = (state == S_SAMPLE) && hit;
    assign fail   = (state == S_SAMPLE) && !hit && last;

    // timer load points
    always_comb begin
        t_load = 1'b0;
        t_val  = SET_LD;
        if (accept && cmd_in.op == OP_START) t_load = 1'b1;
        if (state == S_RSTP || state == S_CTRL) t_load = 1'b1;
        if ((state == S_PHYSET && t_zero) || (state == S_SAMPLE && !hit && !last)) begin
            t_load = 1'b1;
            t_val  = POLL_LD;
        end
    end

    bringup_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cur      <= '0;
            poll_cnt <= '0;
            done_q   <= 1'b0;
            ok_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    cur      <= cmd_in;
                    poll_cnt <= '0;
                    case (cmd_in.op)
                        OP_START: state <= S_CLKSET;
                        OP_RESET: state <= S_RSTP;
                        default: begin
                            done_q <= 1'b1;
                            ok_q   <= 1'b1;
                        end
                    endcase
                end
                S_RSTP:   state <= S_CLKSET;
                S_CLKSET: if (t_zero) state <= S_CTRL;
                S_CTRL:   state <= S_PHYSET;
                S_PHYSET: if (t_zero) state <= S_PWAIT;
                S_PWAIT:  if (t_zero) state <= S_SAMPLE;
                S_SAMPLE: begin
                    if (hit || last) begin
                        done_q <= 1'b1;
                        ok_q   <= hit;
                        state  <= S_IDLE;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        state    <= S_PWAIT;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        logic mine_cmd, mine_cur;
        assign mine_cmd = accept && (cmd_in.port == 1'(i));
        assign mine_cur = (cur.port == 1'(i));
        bringup_port u_port (
            .clk       (clk),
            .rst       (rst),
            .set_clk   (mine_cmd && cmd_in.op == OP_START),
            .clr_clk   ((mine_cmd && cmd_in.op == OP_STOP) ||
                        (fail && mine_cur && cur.op == OP_START)),
            .set_online(succ && mine_cur),
            .clr_online(mine_cmd),
            .clk_en    (port_clk_en[i]),
            .online    (online[i])
        );
        assign port_rst[i] = (state == S_RSTP) && mine_cur;
    end

    assign ctrl_we   = (state == S_CTRL);
    assign ctrl_port = cur.port;
    assign ctrl_data = ctrl_word(cur.port, cur.mux);
    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign result_ok = ok_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst) (|port_rst) |=> !(|port_rst));
    // R7
    rst_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(port_rst));
    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
    // R3
    ctrl_bits_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |-> (ctrl_data[CB_EN] && ctrl_data[CB_HOTPLUG] && !ctrl_we_prev_hi(ctrl_data)));
    // R5
    online_ok_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(online[0]) || $rose(online[1]) |-> done && result_ok);

    function automatic logic ctrl_we_prev_hi(input logic [CTRL_W-1:0] d);
        return |(d & ~CTRL_W'(16'h0013));
    endfunction
endmodule

// File: tb/tb_phy_bringup_seq.sv
module tb_phy_bringup_seq;
    localparam int CPM = 4;
    localparam int D = 10 * CPM;
    localparam int P = 100 * CPM;
    localparam int NPOLL = 10;

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_port = 0;
    logic [1:0] cmd_op = 0, mux_mode = 0, phy_ready = 0;
    logic [1:0] port_clk_en, port_rst, online;
    logic ctrl_we, ctrl_port, busy, done, result_ok;
    logic [15:0] ctrl_data;

    int errors = 0, checks = 0;
    int r_n, r_we_cnt, r_rst_cnt, r_rst_n, r_we_n;
    logic [15:0] r_data;
    logic r_cport, r_ok, r_clk0, r_busy1, r_clk12, r_after;

    always #2 clk = ~clk;

    phy_bringup_seq #(.CYC_PER_MS(CPM)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_port(cmd_port), .mux_mode(mux_mode), .phy_ready(phy_ready),
        .port_clk_en(port_clk_en), .port_rst(port_rst), .ctrl_we(ctrl_we),
        .ctrl_port(ctrl_port), .ctrl_data(ctrl_data), .busy(busy), .done(done),
        .result_ok(result_ok), .online(online)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ready_at: 0 ready from the start, -1 never, otherwise cycle index
    task automatic run(input int op, input logic port, input int mux,
                       input int ready_at, input bit inject);
        @(negedge clk);
        phy_ready[port] = (ready_at == 0);
        cmd_valid = 1; cmd_op = op[1:0]; cmd_port = port; mux_mode = mux[1:0];
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
        r_n = 0; r_we_cnt = 0; r_rst_cnt = 0; r_rst_n = -1; r_we_n = -1;
        r_data = 0; r_cport = 0; r_clk12 = 0; r_busy1 = 0;
        forever begin
            if (r_n == 0) r_clk0 = port_clk_en[port];
            if (r_n == 1) r_busy1 = busy;
            if (r_n == 12) r_clk12 = port_clk_en[port];
            if (ctrl_we) begin r_we_cnt++; r_data = ctrl_data; r_cport = ctrl_port; r_we_n = r_n; end
            if (|port_rst) begin r_rst_cnt++; r_rst_n = r_n; end
            if (ready_at > 0 && r_n == ready_at) phy_ready[port] = 1;
            if (inject && r_n == 10) begin
                cmd_valid = 1; cmd_op = 2'd3; cmd_port = port;
            end
            if (inject && r_n == 11) begin cmd_valid = 0; cmd_op = 0; end
            if (done || r_n > 10000) break;
            @(negedge clk);
            r_n++;
        end
        r_ok = result_ok;
        @(negedge clk);
        r_after = done;
    endtask

    task automatic t_reset_state();
        chk("R1 clk_en", port_clk_en, 0);
        chk("R1 online", online, 0);
        chk("R1 port_rst", port_rst, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
    endtask

    task automatic t_start_ready();
        run(1, 0, 0, 0, 0);
        chk("R2 clk_en at accept", r_clk0, 1);
        chk("R2 busy", r_busy1, 1);
        chk("R3 write count", r_we_cnt, 1);
        chk("R3 word mux0 port0", r_data, 16'h0011);
        chk("R3 ctrl_port", r_cport, 0);
        chk("R4 write cycle", r_we_n, D);
        chk("R4 done cycle k=1", r_n, 2*D + 1 + (P + 1));
        chk("R5 ok", r_ok, 1);
        chk("R5 online0", online[0], 1);
        chk("R10 done single", r_after, 0);
        chk("R10 port1 untouched", {port_clk_en[1], online[1]}, 0);
    endtask

    task automatic t_start_late();
        run(1, 1, 3, 2*D + 1 + 2*(P + 1) + 5, 0);
        chk("R3 word mux3 port1", r_data, 16'h0013);
        chk("R3 ctrl_port", r_cport, 1);
        chk("R4 done cycle k=3", r_n, 2*D + 1 + 3*(P + 1));
        chk("R5 online1", online[1], 1);
        chk("R10 port0 untouched", {port_clk_en[0], online[0]}, 2'b11);
    endtask

    task automatic t_stop();
        run(3, 0, 0, -1, 0);
        chk("R8 done at accept", r_n, 0);
        chk("R8 ok", r_ok, 1);
        chk("R8 clk_en0", port_clk_en[0], 0);
        chk("R8 online0", online[0], 0);
        chk("R10 online1 kept", online[1], 1);
    endtask

    task automatic t_start_fail();
        phy_ready[0] = 0;
        run(1, 0, 2, -1, 0);
        chk("R3 word mux2 port0", r_data, 16'h0013);
        chk("R6 done cycle", r_n, 2*D + 1 + NPOLL*(P + 1));
        chk("R6 result", r_ok, 0);
        chk("R6 clk gated", port_clk_en[0], 0);
        chk("R6 online0", online[0], 0);
    endtask

    task automatic t_reset_ok();
        run(2, 1, 1, 0, 0);
        chk("R7 pulse count", r_rst_cnt, 1);
        chk("R7 pulse cycle", r_rst_n, 0);
        chk("R3 word mux1 port1", r_data, 16'h0011);
        chk("R4 reset write cycle", r_we_n, D + 1);
        chk("R4 reset done cycle", r_n, 2*D + 2 + (P + 1));
        chk("R7 online1", online[1], 1);
    endtask

    task automatic t_reset_fail();
        run(1, 0, 0, 0, 0);
        phy_ready[0] = 0;
        run(2, 0, 0, -1, 0);
        chk("R7 fail done cycle", r_n, 2*D + 2 + NPOLL*(P + 1));
        chk("R7 fail result", r_ok, 0);
        chk("R7 clk kept", port_clk_en[0], 1);
        chk("R6 online0 after fail", online[0], 0);
    endtask

    task automatic t_busy_ignore();
        run(1, 1, 0, 0, 1);
        chk("R9 clk kept", r_clk12, 1);
        chk("R9 timing", r_n, 2*D + 1 + (P + 1));
        chk("R9 ok", r_ok, 1);
        chk("R9 clk after", port_clk_en[1], 1);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        t_reset_state();
        t_start_ready();
        t_start_late();
        t_stop();
        t_start_fail();
        t_reset_ok();
        t_reset_fail();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule